// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block turns the output of an analog comparator into a processor interrupt. The raw comparator output is brought into the clock domain through a flop chain. It is optionally inverted and then compared against a reference bit. Only a processor access to the comparator control register loads that reference bit. While the live output and the reference disagree, a sticky flag is set on every clock. Software ends the condition by touching the control register, then clears the flag. Writing 1 to the flag sets it by hand, which gives a software-triggered interrupt.

A small register bus gives access to four byte-wide registers: comparator control, peripheral flag, peripheral enable and global interrupt control. The single interrupt request goes high only when the flag and all three enable bits are set. The flag itself is never masked.

Reset is synchronous and active high. It must be held for at least `SYNC_STAGES + 1` clocks so that the synchronizer settles. During reset the reference bit tracks the live output, so the block comes out of reset without a false flag.

Top module: `cmpint_change_irq`

## Requirements
- R1: After reset, the flag, enable and global registers read 0x00, and the control register reads 0x00 apart from its status bit. The interrupt request is low, and no flag appears after reset even when the comparator input is held high.
- R2: A change on `cmp_raw_i` made between clock edges sets the flag on the third following rising edge, and not on the second.
- R3: Control register bit 6 reads the synchronized comparator output XOR the invert bit (bit 4). The same inverted value is what the block compares against the reference.
- R4: A read or a write of the control register copies the live value into the reference. After such an access, writing 0 to the flag clears it.
- R5: While a mismatch persists and the control register is not accessed, the flag is set again on every clock. A flag write of 0 in that state leaves the flag at 1.
- R6: Writing the flag register with bit 3 = 0 clears the flag. Writing bit 3 = 1 sets it, with no comparator change, and raises the request when enabled.
- R7: When a control-register read happens in the first cycle the synchronized output differs from the reference, the new value becomes the reference and the flag is not set.
- R8: `irq_o` is 1 only when the flag, the comparator enable, the peripheral enable and the global enable are all 1. With any enable at 0, a mismatch still sets the flag.
- R9: When the mode field (control bits 2:0) is 3'b111, the status bit reads 0 and changes on the comparator input do not set the flag.
- R10: Register map: control at address 0 (invert bit 4, input select bit 3, mode bits 2:0, status bit 6 read-only, bits 7 and 5 read 0). Flag at address 1, bit 3. Comparator enable at address 2, bit 3. Global control at address 3 (global enable bit 7, peripheral enable bit 6). All other bits read 0.
- R11: A control write that changes the invert or mode bits loads the reference with the value computed from the new settings, so the write itself causes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_en_i` is high, 0 otherwise |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that a read and a write never share a cycle, and that reset is held long enough for the synchronizer to settle. The sticky-flag and reference properties are only meaningful under those conditions. The bench drives every strobe for exactly one clock, from the falling edge. It never raises both strobes together, and it holds reset for five clocks. The comparator input changes only on falling edges, so the input latency and the one-cycle read race fall on known edges.

// File: rtl/cmpint_pkg.sv
package cmpint_pkg;

    localparam int unsigned REG_W = 8;

    // bit positions that software decodes
    localparam int unsigned CTL_STATUS_BIT = 6;
    localparam int unsigned CTL_INV_BIT    = 4;
    localparam int unsigned CTL_SEL_BIT    = 3;
    localparam int unsigned FLAG_BIT       = 3;
    localparam int unsigned IE_BIT         = 3;
    localparam int unsigned GIE_BIT        = 7;
    localparam int unsigned PIE_BIT        = 6;

    typedef enum logic [2:0] {
        MODE_0   = 3'b000,
        MODE_OFF = 3'b111
    } mode_e;

    typedef struct packed {
        logic       inv;
        logic       sel;
        logic [2:0] mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{inv: 1'b0, sel: 1'b0, mode: 3'b000};

    function automatic ctrl_t ctrl_from_byte(input logic [REG_W-1:0] b);
        ctrl_t c;
        c.inv  = b[CTL_INV_BIT];
        c.sel  = b[CTL_SEL_BIT];
        c.mode = b[2:0];
        return c;
    endfunction

    function automatic logic ctrl_is_off(input ctrl_t c);
        return c.mode == MODE_OFF;
    endfunction

    // comparator value as seen by software and by the mismatch compare
    function automatic logic gated_out(input logic raw, input ctrl_t c);
        return ctrl_is_off(c) ? 1'b0 : (raw ^ c.inv);
    endfunction

endpackage

// File: rtl/cmpint_sync.sv
module cmpint_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    // no reset: the chain settles while reset is held
    always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[N-2:0], d_i};
    end

    assign q_o = chain_q[N-1];
endmodule

// File: rtl/cmpint_ref.sv
module cmpint_ref (
    input  logic clk_i,
    input  logic rst_i,
    input  logic capture_i,
    input  logic cap_val_i,
    input  logic live_i,
    input  logic active_i,
    output logic mismatch_o
);
    logic ref_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || capture_i) begin
            ref_q <= cap_val_i;
        end
    end

    // an access in progress owns the compare: the sampled value becomes the reference
    assign mismatch_o = active_i && !capture_i && (live_i != ref_q);

    p_access_ends_mismatch_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        capture_i |=> (!mismatch_o || (live_i != $past(cap_val_i))));

    p_race_no_set_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        capture_i |-> !mismatch_o);
endmodule

// File: rtl/cmpint_flag.sv
module cmpint_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic wr_i,
    input  logic wval_i,
    input  logic set_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= 1'b0;
        end else begin
            // a pending mismatch beats a software clear
            flag_q <= (wr_i ? wval_i : flag_q) | set_i;
        end
    end

    assign flag_o = flag_q;

    p_mismatch_sets_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        set_i |=> flag_q);

    p_clear_by_write_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(flag_q) |-> $past(wr_i && !wval_i));

    p_force_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && wval_i) |=> flag_q);
endmodule

// File: rtl/cmpint_change_irq.sv
module cmpint_change_irq
    import cmpint_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CTRL_ADDR   = 0,
    parameter int unsigned FLAG_ADDR   = 1,
    parameter int unsigned IE_ADDR     = 2,
    parameter int unsigned GCTL_ADDR   = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmp_raw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(IE_ADDR);
    localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(GCTL_ADDR);

    ctrl_t ctrl_q, ctrl_next;
    logic  cmp_ie_q, gie_q, pie_q;
    logic  sync_out, live_val, cap_val, mismatch, flag;
    logic  ctrl_acc, ctrl_wr, flag_wr, ie_wr, gctl_wr;
    logic  unused_wbits;

    assign unused_wbits = &{1'b0, wdata_i[5]};

    assign ctrl_acc = (rd_en_i || wr_en_i) && (addr_i == A_CTRL);
    assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
    assign flag_wr  = wr_en_i && (addr_i == A_FLAG);
    assign ie_wr    = wr_en_i && (addr_i == A_IE);
    assign gctl_wr  = wr_en_i && (addr_i == A_GCTL);

    cmpint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .d_i   (cmp_raw_i),
        .q_o   (sync_out)
    );

    assign ctrl_next = ctrl_wr ? ctrl_from_byte(wdata_i) : ctrl_q;
    assign live_val  = gated_out(sync_out, ctrl_q);
    // capture with the settings that will be in force after this access
    assign cap_val   = rst_i ? gated_out(sync_out, CTRL_RESET)
                             : gated_out(sync_out, ctrl_next);

    cmpint_ref u_ref (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .capture_i  (ctrl_acc),
        .cap_val_i  (cap_val),
        .live_i     (live_val),
        .active_i   (!ctrl_is_off(ctrl_q)),
        .mismatch_o (mismatch)
    );

    cmpint_flag u_flag (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_i   (flag_wr),
        .wval_i (wdata_i[FLAG_BIT]),
        .set_i  (mismatch),
        .flag_o (flag)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q   <= CTRL_RESET;
            cmp_ie_q <= 1'b0;
            gie_q    <= 1'b0;
            pie_q    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_next;
            if (ie_wr) begin
                cmp_ie_q <= wdata_i[IE_BIT];
            end
            if (gctl_wr) begin
                gie_q <= wdata_i[GIE_BIT];
                pie_q <= wdata_i[PIE_BIT];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                A_CTRL: begin
                    rdata_o[CTL_STATUS_BIT] = live_val;
                    rdata_o[CTL_INV_BIT]    = ctrl_q.inv;
                    rdata_o[CTL_SEL_BIT]    = ctrl_q.sel;
                    rdata_o[2:0]            = ctrl_q.mode;
                end
                A_FLAG: rdata_o[FLAG_BIT] = flag;
                A_IE:   rdata_o[IE_BIT]   = cmp_ie_q;
                A_GCTL: begin
                    rdata_o[GIE_BIT] = gie_q;
                    rdata_o[PIE_BIT] = pie_q;
                end
                default: rdata_o = '0;
            endcase
        end
    end

    assign irq_o = flag && cmp_ie_q && pie_q && gie_q;

    p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> flag);

    p_irq_needs_global_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !gie_q |-> !irq_o);

    p_off_status_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == A_CTRL && ctrl_is_off(ctrl_q)) |-> !rdata_o[CTL_STATUS_BIT]);

    p_off_no_set_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_is_off(ctrl_q) |-> !mismatch);
endmodule

// File: tb/cmpint_change_irq_tb_top.sv
module cmpint_change_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       raw = 1'b1;
    logic [1:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         n_total = 0;
    int         n_fail = 0;
    bit         done = 0;

    localparam logic [1:0] A_CTRL = 2'd0, A_FLAG = 2'd1, A_IE = 2'd2, A_GCTL = 2'd3;

    always #5 clk = ~clk;

    cmpint_change_irq dut_i (
        .clk_i(clk), .rst_i(rst), .cmp_raw_i(raw), .addr_i(addr),
        .rd_en_i(rd), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        bread(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic t_reset();
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R1 flag after reset");
        expect_reg(A_IE, 8'h00, "R1 enable after reset");
        expect_reg(A_GCTL, 8'h00, "R1 global after reset");
        expect_reg(A_CTRL, 8'h40, "R1 control after reset");
        chk(irq == 1'b0, "R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_layout();
        bwrite(A_CTRL, 8'hFF);
        expect_reg(A_CTRL, 8'h1F, "R10 control layout");
        bwrite(A_CTRL, 8'h00);
        bwrite(A_IE, 8'hFF);
        expect_reg(A_IE, 8'h08, "R10 enable layout");
        bwrite(A_GCTL, 8'hFF);
        expect_reg(A_GCTL, 8'hC0, "R10 global layout");
        bwrite(A_FLAG, 8'hF7);
        expect_reg(A_FLAG, 8'h00, "R10 flag layout");
    endtask

    task automatic t_latency();
        @(negedge clk);
        raw = 1'b0;
        @(posedge clk); @(posedge clk);
        #1 chk(irq == 1'b0, "R2 no flag at second edge", {7'b0, irq}, 8'h00);
        @(posedge clk);
        #1 chk(irq == 1'b1, "R2 flag at third edge", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_persist();
        bwrite(A_FLAG, 8'h00);
        expect_reg(A_FLAG, 8'h08, "R5 clear refused while mismatch persists");
        expect_reg(A_CTRL, 8'h00, "R3 status follows input 0");
        bwrite(A_FLAG, 8'h00);
        expect_reg(A_FLAG, 8'h00, "R4 clear after control read");
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R4 flag stays clear");
    endtask

    task automatic t_force();
        bwrite(A_FLAG, 8'h08);
        expect_reg(A_FLAG, 8'h08, "R6 forced flag");
        chk(irq == 1'b1, "R6 forced irq", {7'b0, irq}, 8'h01);
        bwrite(A_FLAG, 8'h00);
        expect_reg(A_FLAG, 8'h00, "R6 flag cleared");
        chk(irq == 1'b0, "R6 irq after clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_gating();
        bwrite(A_FLAG, 8'h08);
        bwrite(A_GCTL, 8'h40);
        chk(irq == 1'b0, "R8 global off", {7'b0, irq}, 8'h00);
        bwrite(A_GCTL, 8'h80);
        chk(irq == 1'b0, "R8 peripheral off", {7'b0, irq}, 8'h00);
        bwrite(A_GCTL, 8'hC0);
        chk(irq == 1'b1, "R8 all on", {7'b0, irq}, 8'h01);
        bwrite(A_IE, 8'h00);
        chk(irq == 1'b0, "R8 comparator enable off", {7'b0, irq}, 8'h00);
        bwrite(A_FLAG, 8'h00);
        @(negedge clk);
        raw = 1'b1;
        idle(5);
        expect_reg(A_FLAG, 8'h08, "R8 flag sets while masked");
        chk(irq == 1'b0, "R8 masked irq", {7'b0, irq}, 8'h00);
        expect_reg(A_CTRL, 8'h40, "R3 status follows input 1");
        bwrite(A_FLAG, 8'h00);
        bwrite(A_IE, 8'h08);
        expect_reg(A_FLAG, 8'h00, "R4 cleared after read");
    endtask

    task automatic t_invert();
        bwrite(A_CTRL, 8'h10);
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R11 invert write raises no flag");
        expect_reg(A_CTRL, 8'h10, "R3 inverted status");
        @(negedge clk);
        raw = 1'b0;
        idle(5);
        expect_reg(A_FLAG, 8'h08, "R3 inverted change sets flag");
        expect_reg(A_CTRL, 8'h50, "R3 inverted status of 0");
        bwrite(A_FLAG, 8'h00);
        bwrite(A_CTRL, 8'h00);
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R11 restore raises no flag");
    endtask

    task automatic t_off();
        bwrite(A_CTRL, 8'h07);
        @(negedge clk);
        raw = 1'b1;
        idle(5);
        expect_reg(A_FLAG, 8'h00, "R9 no flag when off");
        expect_reg(A_CTRL, 8'h07, "R9 status zero when off");
        bwrite(A_CTRL, 8'h00);
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R11 mode write raises no flag");
    endtask

    task automatic t_race();
        logic [7:0] v;
        @(negedge clk);
        raw = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        addr = A_CTRL; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
        chk(v[6] == 1'b0, "R7 read sees new value", v, 8'h00);
        idle(4);
        expect_reg(A_FLAG, 8'h00, "R7 flag not set in race");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        bwrite(A_IE, 8'h08);
        bwrite(A_GCTL, 8'hC0);
        t_latency();
        t_persist();
        t_force();
        t_gating();
        t_invert();
        t_off();
        t_race();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule